// File: doc/BRIEF.md
# Pipeline Hazard Detection and Stall Unit

This unit sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose branches are compared and resolved during decode. Each cycle it looks at the two source register numbers of the decoding instruction and at the destination number and control flags of the instructions now in the execute and memory stages. From these it decides whether the decoding instruction must wait.

When it must wait, the unit freezes the program counter and the fetch/decode register, so the same instruction is decoded again and its successor fetched again. It also tells the decode/execute register to take all-zero control values, which sends a bubble down the pipe. A plain instruction that consumes a load result waits one cycle. A branch waits for its compare operands: one cycle behind an ALU producer or a load two slots ahead, and two cycles directly behind a load. When a taken branch leaves decode, the unit flushes the one instruction fetched behind it.

Stalls are counted. On the first cycle of a hazard the unit loads a small down-counter with the full length of the stall, and the stall then runs out without looking at the producer flags again.

Top module: `hazard_unit`

## Requirements
- R1: When the execute-stage instruction is a load (memory read and register write) whose nonzero destination equals the decode instruction's first or second source, the unit stalls in that cycle; a non-branch consumer directly behind a load waits exactly one cycle.
- R2: In a stall cycle pc_we=0, ifid_we=0 and idex_ctrl_zero=1; in every other cycle pc_we=1, ifid_we=1 and idex_ctrl_zero=0.
- R3: A branch in decode whose source is written by the ALU instruction directly ahead of it (in execute, register write, no memory read) waits exactly one cycle.
- R4: A branch in decode whose source is written by a load two instructions ahead of it (that load in the memory stage) waits exactly one cycle.
- R5: A branch in decode directly behind a load that writes one of its sources waits exactly two cycles.
- R6: A branch or other instruction whose producer is an ALU instruction two or three places ahead does not wait.
- R7: A destination of register 0, or a producer with its register-write flag low, never causes a stall.
- R8: ifid_flush is 1 exactly when the decode instruction is a branch flagged taken and the unit is not stalling in that cycle.
- R9: Reset clears any stall in progress: after reset, with no producer hazard at the inputs, the unit does not stall.
- R10: Once a two-cycle branch stall has begun, its second cycle stalls even if the execute and memory inputs then show no producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | AW | First source register of the decode instruction |
| id_rt | input | AW | Second source register of the decode instruction |
| id_branch | input | 1 | Decode instruction is a compare-in-decode branch |
| id_taken | input | 1 | Branch comparison in decode says taken |
| ex_dst | input | AW | Destination register of the execute-stage instruction |
| ex_mem_read | input | 1 | Execute-stage instruction reads memory |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | AW | Destination register of the memory-stage instruction |
| mem_mem_read | input | 1 | Memory-stage instruction reads memory |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_ctrl_zero | output | 1 | Force zero control values into decode/execute |
| ifid_flush | output | 1 | Clear the fetch/decode register after a taken branch |

## Verification
The only internal state is the stall down-counter, and a wrong value in it shows at the ports on the very next cycle: a stuck nonzero count keeps pc_we low past the expected window, and a lost count ends a two-cycle branch stall after one, letting the branch compare against a stale operand. The bench therefore models a pipeline fed by the unit's own stall decisions and checks all four outputs every cycle, through directed load, ALU and branch sequences and a long random instruction stream, so a counter error surfaces within one or two cycles of the hazard that loaded it. Forcing the producer inputs quiet in the middle of a two-cycle stall, and resetting in the middle of one, separate the counted stall from a purely combinational one.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // width of the stall down-counter; longest stall is two cycles
    localparam int HZ_CW = 2;

    // stall lengths per hazard class
    localparam int HZ_LOAD_USE    = 1;
    localparam int HZ_BR_ALU_NEAR = 1;
    localparam int HZ_BR_LOAD_FAR = 1;
    localparam int HZ_BR_LOAD_NEAR = 2;

    typedef logic [HZ_CW-1:0] hz_cnt_t;

    typedef struct packed {
        hz_cnt_t left;
    } hz_state_t;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic ctrl_zero;
        logic flush;
    } hz_ctl_t;

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC*AW-1:0] srcs,
    input  logic [AW-1:0]      dst,
    input  logic               reg_write,
    output logic               hit
);
    logic [NSRC-1:0] per_src;
    logic            producer;

    // a producer must write a register other than register 0
    assign producer = reg_write && (dst != '0);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign per_src[g] = producer && (srcs[g*AW +: AW] == dst);
    end

    assign hit = |per_src;
endmodule

// File: rtl/hz_need.sv
module hz_need
    import hz_pkg::*;
(
    input  logic    id_branch,
    input  logic    ex_hit,
    input  logic    ex_load,
    input  logic    mem_hit,
    input  logic    mem_load,
    output hz_cnt_t need
);
    always_comb begin
        need = '0;
        if (ex_hit && ex_load) begin
            if (id_branch) begin
                need = hz_cnt_t'(HZ_BR_LOAD_NEAR);
            end else begin
                need = hz_cnt_t'(HZ_LOAD_USE);
            end
        end else if (id_branch && ex_hit) begin
            need = hz_cnt_t'(HZ_BR_ALU_NEAR);
        end else if (id_branch && mem_hit && mem_load) begin
            need = hz_cnt_t'(HZ_BR_LOAD_FAR);
        end
    end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic          id_branch,
    input  logic          id_taken,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_mem_read,
    input  logic          ex_reg_write,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_mem_read,
    input  logic          mem_reg_write,
    output logic          pc_we,
    output logic          ifid_we,
    output logic          idex_ctrl_zero,
    output logic          ifid_flush
);
    localparam int NSRC = 2;

    logic [NSRC*AW-1:0] srcs;
    logic               ex_hit;
    logic               mem_hit;
    hz_cnt_t            need;
    hz_state_t          st_d, st_q;
    hz_ctl_t            ctl;

    assign srcs = {id_rt, id_rs};

    hz_src_match #(.AW(AW), .NSRC(NSRC)) u_ex_match (
        .srcs      (srcs),
        .dst       (ex_dst),
        .reg_write (ex_reg_write),
        .hit       (ex_hit)
    );

    hz_src_match #(.AW(AW), .NSRC(NSRC)) u_mem_match (
        .srcs      (srcs),
        .dst       (mem_dst),
        .reg_write (mem_reg_write),
        .hit       (mem_hit)
    );

    hz_need u_need (
        .id_branch (id_branch),
        .ex_hit    (ex_hit),
        .ex_load   (ex_mem_read),
        .mem_hit   (mem_hit),
        .mem_load  (mem_mem_read),
        .need      (need)
    );

    always_comb begin
        logic stall;
        st_d  = st_q;
        stall = 1'b0;
        if (st_q.left != '0) begin
            // stall window already running: count it out
            stall      = 1'b1;
            st_d.left  = st_q.left - hz_cnt_t'(1);
        end else if (need != '0) begin
            // first cycle of a new hazard: this cycle counts as one
            stall      = 1'b1;
            st_d.left  = need - hz_cnt_t'(1);
        end
        ctl.pc_we     = ~stall;
        ctl.ifid_we   = ~stall;
        ctl.ctrl_zero = stall;
        ctl.flush     = id_branch && id_taken && !stall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_we          = ctl.pc_we;
    assign ifid_we        = ctl.ifid_we;
    assign idex_ctrl_zero = ctl.ctrl_zero;
    assign ifid_flush     = ctl.flush;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] id_rs,
    input logic [AW-1:0] id_rt,
    input logic          id_branch,
    input logic          id_taken,
    input logic [AW-1:0] ex_dst,
    input logic          ex_mem_read,
    input logic          ex_reg_write,
    input logic [AW-1:0] mem_dst,
    input logic          mem_mem_read,
    input logic          mem_reg_write,
    input logic          pc_we,
    input logic          ifid_we,
    input logic          idex_ctrl_zero,
    input logic          ifid_flush
);
    logic ex_prod, mem_prod, prev_stall;

    assign ex_prod  = ex_reg_write && (ex_dst != '0) &&
                      ((ex_dst == id_rs) || (ex_dst == id_rt));
    assign mem_prod = mem_reg_write && (mem_dst != '0) &&
                      ((mem_dst == id_rs) || (mem_dst == id_rt));

    always_ff @(posedge clk) begin
        if (!rst_n) prev_stall <= 1'b0;
        else        prev_stall <= idex_ctrl_zero;
    end

    // R1
    load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_prod && ex_mem_read) |-> idex_ctrl_zero);

    // R2
    we_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (idex_ctrl_zero != pc_we));

    // R5
    br_load_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_branch && ex_prod && ex_mem_read && !prev_stall) |=> idex_ctrl_zero);

    // R6 R7
    no_false_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_stall && !ex_prod && !(mem_prod && mem_mem_read)) |-> !idex_ctrl_zero);

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (id_branch && id_taken && !idex_ctrl_zero));
endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/hazard_unit_tb.sv
module hazard_unit_tb;
    localparam int AW = 5;

    typedef struct packed {
        logic [AW-1:0] rs;
        logic [AW-1:0] rt;
        logic [AW-1:0] dst;
        logic          load;
        logic          regw;
        logic          br;
        logic          taken;
    } ins_t;

    localparam ins_t NOP = '0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs = '0, id_rt = '0, ex_dst = '0, mem_dst = '0;
    logic          id_branch = 0, id_taken = 0;
    logic          ex_mem_read = 0, ex_reg_write = 0;
    logic          mem_mem_read = 0, mem_reg_write = 0;
    logic          pc_we, ifid_we, idex_ctrl_zero, ifid_flush;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    ins_t ex_m = NOP, mem_m = NOP;

    always #5 clk = ~clk;

    hazard_unit #(.AW(AW)) u_dut (
        .clk, .rst_n, .id_rs, .id_rt, .id_branch, .id_taken,
        .ex_dst, .ex_mem_read, .ex_reg_write,
        .mem_dst, .mem_mem_read, .mem_reg_write,
        .pc_we, .ifid_we, .idex_ctrl_zero, .ifid_flush
    );

    function automatic ins_t alu(int d, int s, int t);
        ins_t i = NOP;
        i.dst = AW'(d); i.rs = AW'(s); i.rt = AW'(t); i.regw = 1;
        return i;
    endfunction

    function automatic ins_t ld(int d, int base);
        ins_t i = NOP;
        i.dst = AW'(d); i.rs = AW'(base); i.load = 1; i.regw = 1;
        return i;
    endfunction

    function automatic ins_t br(int s, int t, bit tk);
        ins_t i = NOP;
        i.rs = AW'(s); i.rt = AW'(t); i.br = 1; i.taken = tk;
        return i;
    endfunction

    function automatic bit produces(ins_t p, ins_t c);
        return p.regw && (p.dst != '0) && ((p.dst == c.rs) || (p.dst == c.rt));
    endfunction

    // stateless specification of the stall decision for a consistent pipeline
    function automatic bit exp_stall(ins_t id, ins_t ex, ins_t mem);
        return (produces(ex, id) && ex.load) ||
               (id.br && produces(ex, id)) ||
               (id.br && produces(mem, id) && mem.load);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(ins_t id, ins_t ex, ins_t mem);
        id_rs = id.rs; id_rt = id.rt; id_branch = id.br; id_taken = id.taken;
        ex_dst = ex.dst; ex_mem_read = ex.load; ex_reg_write = ex.regw;
        mem_dst = mem.dst; mem_mem_read = mem.load; mem_reg_write = mem.regw;
    endtask

    task automatic step(ins_t id, output bit st);
        @(negedge clk);
        drive(id, ex_m, mem_m);
        #1;
        st = exp_stall(id, ex_m, mem_m);
        chk({pc_we, ifid_we, idex_ctrl_zero} == {~st, ~st, st}, "R2 stall outputs",
            int'({pc_we, ifid_we, idex_ctrl_zero}), int'({~st, ~st, st}));
        chk(ifid_flush == (id.br && id.taken && !st), "R8 flush",
            int'(ifid_flush), int'(id.br && id.taken && !st));
        mem_m = ex_m;
        ex_m  = st ? NOP : id;
    endtask

    task automatic issue(ins_t i, output int stalls);
        bit st;
        stalls = 0;
        do begin
            step(i, st);
            if (st) stalls++;
        end while (st);
        if (i.br && i.taken) step(NOP, st);
    endtask

    task automatic drain();
        int n;
        for (int k = 0; k < 3; k++) issue(NOP, n);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        bit st;
        void'($urandom(32'd20240517));
        drive(NOP, NOP, NOP);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R9 reset state
        chk(pc_we && ifid_we && !idex_ctrl_zero && !ifid_flush, "R9 reset state",
            int'({pc_we, ifid_we, idex_ctrl_zero, ifid_flush}), 4'b1100);

        // R1 load then dependent ALU op, match on either source
        issue(ld(2, 3), n); issue(alu(12, 2, 5), n);
        chk(n == 1, "R1 load-use rs", n, 1);
        drain();
        issue(ld(4, 3), n); issue(alu(9, 7, 4), n);
        chk(n == 1, "R1 load-use rt", n, 1);
        drain();

        // R5 branch directly behind load
        issue(ld(1, 3), n); issue(br(1, 4, 0), n);
        chk(n == 2, "R5 load then branch", n, 2);
        drain();

        // R3 branch directly behind ALU producer
        issue(alu(1, 2, 3), n); issue(br(5, 1, 0), n);
        chk(n == 1, "R3 alu then branch", n, 1);
        drain();

        // R4 load two ahead of branch
        issue(ld(1, 3), n); issue(alu(4, 5, 6), n); issue(br(1, 0, 0), n);
        chk(n == 1, "R4 load two ahead", n, 1);
        drain();

        // R6 ALU producers second and third ahead
        issue(alu(1, 2, 3), n); issue(alu(7, 2, 3), n); issue(br(1, 0, 0), n);
        chk(n == 0, "R6 alu second ahead", n, 0);
        drain();
        issue(alu(1, 2, 3), n); issue(alu(7, 2, 3), n); issue(alu(8, 2, 3), n);
        issue(br(0, 1, 0), n);
        chk(n == 0, "R6 alu third ahead", n, 0);
        drain();

        // R7 register 0 and no register write
        issue(ld(0, 3), n); issue(br(0, 0, 0), n);
        chk(n == 0, "R7 dest r0", n, 0);
        drain();
        begin
            ins_t sw = ld(2, 3);
            sw.regw = 0; sw.load = 0;
            issue(sw, n); issue(br(2, 2, 0), n);
            chk(n == 0, "R7 no regwrite", n, 0);
        end
        drain();

        // R8 taken branch flush, with and without preceding stall
        issue(br(3, 3, 1), n);
        chk(n == 0, "R8 taken no hazard", n, 0);
        issue(alu(6, 1, 1), n); issue(br(6, 6, 1), n);
        chk(n == 1, "R8 taken after stall", n, 1);
        drain();

        // R10 second cycle of two-cycle stall ignores quiet producer inputs
        step(ld(3, 1), st);
        step(br(3, 0, 1), st);
        @(negedge clk);
        drive(br(3, 0, 1), NOP, NOP);
        #1;
        chk(idex_ctrl_zero == 1'b1 && ifid_flush == 1'b0, "R10 counted stall",
            int'(idex_ctrl_zero), 1);
        @(negedge clk);
        drive(br(3, 0, 1), NOP, NOP);
        #1;
        chk(idex_ctrl_zero == 1'b0 && ifid_flush == 1'b1, "R10 window ends",
            int'(idex_ctrl_zero), 0);
        ex_m = NOP; mem_m = NOP;
        drain();

        // R9 reset in the middle of a two-cycle stall
        step(ld(3, 1), st);
        step(br(3, 0, 0), st);
        @(negedge clk);
        rst_n = 1'b0;
        drive(NOP, NOP, NOP);
        @(negedge clk);
        rst_n = 1'b1;
        drive(br(3, 0, 0), NOP, NOP);
        #1;
        chk(idex_ctrl_zero == 1'b0 && pc_we == 1'b1, "R9 reset clears stall",
            int'(idex_ctrl_zero), 0);
        ex_m = NOP; mem_m = NOP;
        drain();

        // random stream over a few registers to provoke hazards (R1 R3 R4 R5 R6 R7)
        for (int k = 0; k < 3000; k++) begin
            ins_t i = NOP;
            int kind = int'($urandom_range(0, 4));
            i.rs  = AW'($urandom_range(0, 3));
            i.rt  = AW'($urandom_range(0, 3));
            i.dst = AW'($urandom_range(0, 3));
            case (kind)
                0: begin i.load = 1; i.regw = 1; end
                1: i.regw = 1;
                2: begin i.br = 1; i.dst = '0; i.taken = 1'($urandom_range(0, 1)); end
                3: i.regw = 0;
                default: i.regw = 1;
            endcase
            issue(i, n);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule